// File: doc/BRIEF.md
# Banked Dual-Port Word Memory with 16-bit Bus Window

This block stores `DEPTH` words of `WIDTH` bits and offers them on two synchronous ports. The user port moves whole words at addresses `0` to `DEPTH-1`. The bus port is a 16-bit register-style port. It sees the same storage as 16-bit chunks inside an address window that starts at `BASE_ADDR`.

Inside, each word is cut into `ceil(WIDTH/16)` chunks. Each chunk lives in its own bank of `DEPTH` entries. The last bank holds only the leftover bits, so it can be narrower than 16. On the bus the banks are laid out one after another: bank 0 takes `DEPTH` consecutive addresses, then bank 1 follows, and so on.

A build-time parameter sets which port may write and which may read. The choices are both ports fully, user-writes/bus-reads, or bus-writes/user-reads. Typical use is a capture buffer read by a host, a pattern buffer loaded by a host, or a shared scratch area.

Top module: `banked_dual_mem`

## Requirements
- R1: After reset, `usr_rdata`, `bus_rdata` and `bus_rvalid` are zero, and every location reads as zero from both ports.
- R2: Chunk `i` of user word `a` is bits `[16*i+15:16*i]` of that word. It is reached on the bus at address `BASE_ADDR + a + i*DEPTH`, so a word written on the user port reads back chunk by chunk on the bus.
- R3: 16-bit chunks written on the bus port read back on the user port combined into one word, with chunk 0 in the least significant bits.
- R4: The last bank is `WIDTH - 16*(nbanks-1)` bits wide. Bus writes to it keep only those low bits, and bus reads from it return zeros above them.
- R5: A bus access to an address below `BASE_ADDR` or above `BASE_ADDR + nbanks*DEPTH - 1` is ignored. A write changes no location. A read gives no `bus_rvalid` and leaves `bus_rdata` unchanged.
- R6: Both ports have one cycle of read latency. `bus_rvalid` is high exactly in the cycle after an accepted bus read, and `usr_rdata` changes only in the cycle after `usr_rd_en`.
- R7: In bidirectional mode, when both ports write the same bank entry in the same cycle, the user-port data is stored.
- R8: In user-write/bus-read mode, bus writes change nothing, and `usr_rd_en` has no effect (`usr_rdata` holds its value).
- R9: In bus-write/user-read mode, user writes change nothing, and bus reads produce no `bus_rvalid` and leave `bus_rdata` unchanged.
- R10: A read of an entry in the same cycle as a write to it returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_wr_en | input | 1 | User-port write strobe |
| usr_rd_en | input | 1 | User-port read strobe |
| usr_addr | input | AW | User word address |
| usr_wdata | input | WIDTH | User write word |
| usr_rdata | output | WIDTH | User read word, one cycle after the request |
| bus_wr_en | input | 1 | Bus-port write strobe |
| bus_rd_en | input | 1 | Bus-port read strobe |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 16 | Bus write chunk |
| bus_rdata | output | 16 | Bus read chunk, zero-extended |
| bus_rvalid | output | 1 | Pulses one cycle after an accepted bus read |

## Verification
The bench goes after the places where the chunk mapping can slip.

- If the mapping is bank-major versus entry-major, or off by one at the edge of a bank, chunks show up at the wrong bus address.
- If the narrow last bank is not masked, stray upper bits leak into bus reads.
- If the window compare is off by one at either end, a write lands in a bank it should have missed, or a read answers with `bus_rvalid`.
- If the priority on a same-cycle collision is reversed, the bus chunk wins where the user word should.
- If read and write ordering is wrong, a same-cycle read returns the new data instead of the old.

All three port-direction builds get the same traffic. A build that leaks a forbidden direction changes memory contents or raises strobes that the reference model does not expect.

// File: rtl/banked_mem_pkg.sv
package banked_mem_pkg;
  typedef enum logic [1:0] {
    PM_BIDIR       = 2'd0,
    PM_USR_TO_BUS  = 2'd1,
    PM_BUS_TO_USR  = 2'd2
  } port_mode_e;

  localparam int CHUNK_W = 16;
endpackage

// File: rtl/bank_store.sv
module bank_store #(
  parameter int BW    = 16,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          u_we,
  input  logic [AW-1:0] u_addr,
  input  logic [BW-1:0] u_wdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [BW-1:0] b_wdata,
  output logic [BW-1:0] u_rdata,
  output logic [BW-1:0] b_rdata
);
  logic [BW-1:0] mem_q [DEPTH];
  logic [BW-1:0] ent_d [DEPTH];
  logic          ent_en [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic u_hit, b_hit;
    assign u_hit = u_we && (int'(u_addr) == i);
    assign b_hit = b_we && (int'(b_addr) == i);

    always_comb begin
      ent_en[i] = u_hit || b_hit;
      ent_d[i]  = u_hit ? u_wdata : b_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[i] <= '0;
      end else if (ent_en[i]) begin
        mem_q[i] <= ent_d[i];
      end
    end
  end

  always_comb begin
    u_rdata = '0;
    b_rdata = '0;
    if (int'(u_addr) < DEPTH) u_rdata = mem_q[u_addr];
    if (int'(b_addr) < DEPTH) b_rdata = mem_q[b_addr];
  end

  // R7: the user port takes priority on a same-entry collision
  p_user_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (u_we && b_we && (u_addr == b_addr) && (int'(u_addr) < DEPTH))
      |=> (mem_q[$past(u_addr)] == $past(u_wdata)));
endmodule

// File: rtl/bus_window.sv
module bus_window #(
  parameter int DEPTH     = 16,
  parameter int NB        = 3,
  parameter int BASE_ADDR = 256,
  parameter int AW        = 4
) (
  input  logic [15:0]   bus_addr,
  output logic          hit,
  output logic [NB-1:0] bank_sel,
  output logic [AW-1:0] entry
);
  localparam int SPAN = NB * DEPTH;

  int off;

  always_comb begin
    off      = int'(bus_addr) - BASE_ADDR;
    bank_sel = '0;
    entry    = '0;
    for (int b = 0; b < NB; b++) begin
      if (off >= b * DEPTH && off < (b + 1) * DEPTH) begin
        bank_sel[b] = 1'b1;
        entry       = AW'(off - b * DEPTH);
      end
    end
    hit = (off >= 0) && (off < SPAN);
  end

  // R2: an address selects at most one bank
  always_comb begin
    p_onehot_sel_r2: assert ($onehot0(bank_sel));
  end
endmodule

// File: rtl/banked_dual_mem.sv
module banked_dual_mem
  import banked_mem_pkg::*;
#(
  parameter int         WIDTH     = 40,
  parameter int         DEPTH     = 16,
  parameter int         BASE_ADDR = 256,
  parameter port_mode_e MODE      = PM_BIDIR,
  localparam int        AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             usr_wr_en,
  input  logic             usr_rd_en,
  input  logic [AW-1:0]    usr_addr,
  input  logic [WIDTH-1:0] usr_wdata,
  output logic [WIDTH-1:0] usr_rdata,
  input  logic             bus_wr_en,
  input  logic             bus_rd_en,
  input  logic [15:0]      bus_addr,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  output logic             bus_rvalid
);
  localparam int  NB     = (WIDTH + CHUNK_W - 1) / CHUNK_W;
  localparam int  LAST_W = WIDTH - CHUNK_W * (NB - 1);
  localparam bit  U_WR   = (MODE != PM_BUS_TO_USR);
  localparam bit  U_RD   = (MODE != PM_USR_TO_BUS);
  localparam bit  B_WR   = (MODE != PM_USR_TO_BUS);
  localparam bit  B_RD   = (MODE != PM_BUS_TO_USR);

  logic          win_hit;
  logic [NB-1:0] bank_sel;
  logic [AW-1:0] bus_entry;

  bus_window #(
    .DEPTH(DEPTH), .NB(NB), .BASE_ADDR(BASE_ADDR), .AW(AW)
  ) u_win (
    .bus_addr (bus_addr),
    .hit      (win_hit),
    .bank_sel (bank_sel),
    .entry    (bus_entry)
  );

  logic [WIDTH-1:0]   u_word;
  logic [CHUNK_W-1:0] b_chunk [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int BW = (b == NB - 1) ? LAST_W : CHUNK_W;
    logic [BW-1:0] u_rd, b_rd;
    logic          b_we;

    assign b_we = bus_wr_en && B_WR && bank_sel[b];

    bank_store #(.BW(BW), .DEPTH(DEPTH), .AW(AW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .u_we    (usr_wr_en && U_WR),
      .u_addr  (usr_addr),
      .u_wdata (usr_wdata[CHUNK_W*b +: BW]),
      .b_we    (b_we),
      .b_addr  (bus_entry),
      .b_wdata (bus_wdata[BW-1:0]),
      .u_rdata (u_rd),
      .b_rdata (b_rd)
    );

    assign u_word[CHUNK_W*b +: BW] = u_rd;

    always_comb begin
      b_chunk[b]         = '0;
      b_chunk[b][BW-1:0] = b_rd;
    end
  end

  logic [CHUNK_W-1:0] bus_mux;
  always_comb begin
    bus_mux = '0;
    for (int b = 0; b < NB; b++) begin
      if (bank_sel[b]) bus_mux = bus_mux | b_chunk[b];
    end
  end

  // next-state logic
  logic             bus_fire;
  logic             usr_en;
  logic [WIDTH-1:0] usr_rdata_d;
  logic [15:0]      bus_rdata_d;
  logic             bus_rvalid_d;

  always_comb begin
    usr_en       = usr_rd_en && U_RD;
    bus_fire     = bus_rd_en && B_RD && win_hit;
    usr_rdata_d  = u_word;
    bus_rdata_d  = bus_mux;
    bus_rvalid_d = bus_fire;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usr_rdata <= '0;
    end else if (usr_en) begin
      usr_rdata <= usr_rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_fire) begin
      bus_rdata <= bus_rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rvalid_d;
    end
  end

  // R6: a valid strobe is always preceded by a read request
  p_rvalid_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_rd_en));

  // R6: without a user read request the user data holds
  p_usr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !usr_rd_en |=> $stable(usr_rdata));

  // R5: reads outside the window stay silent
  p_outside_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && !win_hit) |=> (!bus_rvalid && $stable(bus_rdata)));

  // R4: reads of the narrow last bank carry no upper bits
  p_narrow_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && $past(bank_sel[NB-1])) |-> ((bus_rdata >> LAST_W) == 16'd0));

  if (MODE == PM_USR_TO_BUS) begin : g_chk_u2b
    // R8: user reads are blocked in this mode
    p_usr_rd_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(usr_rdata));
  end
  if (MODE == PM_BUS_TO_USR) begin : g_chk_b2u
    // R9: bus reads are blocked in this mode
    p_bus_rd_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rvalid);
  end
endmodule

// File: tb/tb_banked_dual_mem.sv
`timescale 1ns/1ps
module tb_banked_dual_mem;
  import banked_mem_pkg::*;

  localparam int W    = 40;
  localparam int D    = 16;
  localparam int BASE = 256;
  localparam int NB   = 3;
  localparam int AW   = 4;
  localparam logic [47:0] MASK = 48'h00FF_FFFF_FFFF;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          uwe, ure, bwe, bre;
  logic [AW-1:0] ua;
  logic [W-1:0]  uwd;
  logic [15:0]   ba, bwd;

  logic [W-1:0] u_rd [3];
  logic [15:0]  b_rd [3];
  logic         b_v  [3];

  banked_dual_mem #(.WIDTH(W), .DEPTH(D), .BASE_ADDR(BASE), .MODE(PM_BIDIR)) dut (
    .clk(clk), .rst_n(rst_n), .usr_wr_en(uwe), .usr_rd_en(ure), .usr_addr(ua),
    .usr_wdata(uwd), .usr_rdata(u_rd[0]), .bus_wr_en(bwe), .bus_rd_en(bre),
    .bus_addr(ba), .bus_wdata(bwd), .bus_rdata(b_rd[0]), .bus_rvalid(b_v[0]));

  banked_dual_mem #(.WIDTH(W), .DEPTH(D), .BASE_ADDR(BASE), .MODE(PM_USR_TO_BUS)) dut_u2b (
    .clk(clk), .rst_n(rst_n), .usr_wr_en(uwe), .usr_rd_en(ure), .usr_addr(ua),
    .usr_wdata(uwd), .usr_rdata(u_rd[1]), .bus_wr_en(bwe), .bus_rd_en(bre),
    .bus_addr(ba), .bus_wdata(bwd), .bus_rdata(b_rd[1]), .bus_rvalid(b_v[1]));

  banked_dual_mem #(.WIDTH(W), .DEPTH(D), .BASE_ADDR(BASE), .MODE(PM_BUS_TO_USR)) dut_b2u (
    .clk(clk), .rst_n(rst_n), .usr_wr_en(uwe), .usr_rd_en(ure), .usr_addr(ua),
    .usr_wdata(uwd), .usr_rdata(u_rd[2]), .bus_wr_en(bwe), .bus_rd_en(bre),
    .bus_addr(ba), .bus_wdata(bwd), .bus_rdata(b_rd[2]), .bus_rvalid(b_v[2]));

  // reference model, index 0 bidir, 1 user->bus, 2 bus->user
  logic [47:0] mdl   [3][D];
  logic [W-1:0] exp_u [3];
  logic [15:0]  exp_b [3];
  logic         exp_v [3];

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input string what, input int k,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s dut%0d actual=%h expected=%h", req, what, k, act, exp);
    end
  endtask

  task automatic step(input string req,
                      input logic iuwe, input logic iure, input int iua, input logic [W-1:0] iuwd,
                      input logic ibwe, input logic ibre, input int iba, input logic [15:0] ibwd);
    @(negedge clk);
    uwe = iuwe; ure = iure; ua = AW'(iua); uwd = iuwd;
    bwe = ibwe; bre = ibre; ba = 16'(iba); bwd = ibwd;
    for (int k = 0; k < 3; k++) begin
      bit aw_u = (k != 2), ar_u = (k != 1), aw_b = (k != 1), ar_b = (k != 2);
      bit inwin = (iba >= BASE) && (iba < BASE + NB * D);
      int off = iba - BASE;
      int bk  = inwin ? off / D : 0;
      int e   = inwin ? off % D : 0;
      if (iure && ar_u) exp_u[k] = mdl[k][iua][W-1:0];
      exp_v[k] = 1'b0;
      if (ibre && ar_b && inwin) begin
        exp_v[k] = 1'b1;
        exp_b[k] = mdl[k][e][16*bk +: 16];
      end
      if (ibwe && aw_b && inwin) begin
        mdl[k][e][16*bk +: 16] = ibwd;
        mdl[k][e] = mdl[k][e] & MASK;
      end
      if (iuwe && aw_u) mdl[k][iua] = {8'h00, iuwd};
    end
    @(posedge clk);
    #1;
    for (int k = 0; k < 3; k++) begin
      chk(req, "usr_rdata", k, 64'(u_rd[k]), 64'(exp_u[k]));
      chk(req, "bus_rdata", k, 64'(b_rd[k]), 64'(exp_b[k]));
      chk(req, "bus_rvalid", k, 64'(b_v[k]), 64'(exp_v[k]));
    end
  endtask

  task automatic idle(input string req);
    step(req, 0, 0, 0, '0, 0, 0, 0, 16'h0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    uwe = 0; ure = 0; bwe = 0; bre = 0; ua = '0; uwd = '0; ba = '0; bwd = '0;
    for (int k = 0; k < 3; k++) begin
      exp_u[k] = '0; exp_b[k] = '0; exp_v[k] = 1'b0;
      for (int a = 0; a < D; a++) mdl[k][a] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values at the ports
    for (int k = 0; k < 3; k++) begin
      chk("R1", "usr_rdata", k, 64'(u_rd[k]), 64'h0);
      chk("R1", "bus_rvalid", k, 64'(b_v[k]), 64'h0);
    end
    // R1: every location reads zero
    for (int a = 0; a < D; a++) step("R1", 0, 1, a, '0, 0, 1, BASE + a, 16'h0);
    for (int a = D; a < NB * D; a++) step("R1", 0, 0, 0, '0, 0, 1, BASE + a, 16'h0);

    // R2: user word appears chunk by chunk, chunk 0 least significant
    step("R2", 1, 0, 3, 40'h12_3456_789A, 0, 0, 0, 16'h0);
    step("R2", 0, 0, 0, '0, 0, 1, BASE + 3, 16'h0);
    step("R2", 0, 0, 0, '0, 0, 1, BASE + 3 + D, 16'h0);
    step("R2", 0, 0, 0, '0, 0, 1, BASE + 3 + 2 * D, 16'h0);
    step("R2", 1, 0, 15, 40'hFE_DCBA_9876, 0, 1, BASE + 15, 16'h0);
    step("R2", 0, 0, 0, '0, 0, 1, BASE + 15, 16'h0);
    step("R2", 0, 0, 0, '0, 0, 1, BASE + 16, 16'h0);

    // R3: bus chunks recombine
    step("R3", 0, 0, 0, '0, 1, 0, BASE + 5, 16'hBEEF);
    step("R3", 0, 0, 0, '0, 1, 0, BASE + 5 + D, 16'hCAFE);
    step("R3", 0, 0, 0, '0, 1, 0, BASE + 5 + 2 * D, 16'h0042);
    step("R3", 0, 1, 5, '0, 0, 0, 0, 16'h0);

    // R4: narrow last bank masks writes and zero-fills reads
    step("R4", 0, 0, 0, '0, 1, 0, BASE + 2 * D + 6, 16'hABCD);
    step("R4", 0, 1, 6, '0, 0, 1, BASE + 2 * D + 6, 16'h0);

    // R5: outside the window
    step("R5", 0, 0, 0, '0, 0, 1, BASE + 5, 16'h0);
    step("R5", 0, 0, 0, '0, 1, 1, BASE - 1, 16'h1111);
    step("R5", 0, 0, 0, '0, 1, 1, BASE + NB * D, 16'h2222);
    step("R5", 0, 1, 15, '0, 0, 1, BASE + NB * D - 1, 16'h0);
    step("R5", 0, 1, 0, '0, 0, 1, BASE, 16'h0);

    // R6: latency and hold
    idle("R6");
    idle("R6");

    // R7: same entry written from both ports
    step("R7", 1, 0, 7, 40'h11_2233_4455, 1, 0, BASE + 7 + D, 16'h9999);
    step("R7", 0, 1, 7, '0, 0, 1, BASE + 7 + D, 16'h0);

    // R10: read in the same cycle as a write returns old data
    step("R10", 1, 1, 3, 40'hAA_BBCC_DDEE, 1, 1, BASE + 5, 16'h7777);
    step("R10", 0, 1, 3, '0, 0, 1, BASE + 5, 16'h0);

    // R8 and R9: mode builds under mixed traffic
    step("R8", 0, 1, 5, '0, 1, 0, BASE + 9, 16'h5A5A);
    step("R9", 1, 0, 9, 40'h01_0203_0405, 0, 1, BASE + 9, 16'h0);
    step("R9", 0, 1, 9, '0, 0, 1, BASE + 9 + D, 16'h0);

    // R2 R3 R5 R7: random mix
    for (int n = 0; n < 400; n++) begin
      step("R2", 1'($urandom), 1'($urandom), int'($urandom % D),
           {8'($urandom), 32'($urandom)}, 1'($urandom), 1'($urandom),
           BASE - 8 + int'($urandom % (NB * D + 16)), 16'($urandom));
    end
    idle("R6");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule